// File: doc/BRIEF.md
# Multi-Context Banked Register File

This block is a general-purpose register file that keeps several complete register sets on chip at once. A process index register picks the active set. Each low index value owns a dedicated bank of 32 registers. Every higher index value falls into one shared overflow bank. When the processor moves between two processes that both hold dedicated indices, it needs no register save or restore. Only a process running in the shared bank needs its registers moved to and from memory, and that transfer happens outside this block.

The process index is split into two parts. The bits above the dedicated-bank count are ORed together to form the shared-bank select. When that select is low, the low index bits are joined with the instruction's 5-bit register number to form the physical address. The block has two combinational read ports and one synchronous write port. It also has a strobe that loads the process index, and a flag that shows whether the current process uses the shared bank. The dedicated-bank count is a power-of-two parameter. The split point in the index follows from it.

Top module: `ctxrf_top`

## Requirements
- R1: A synchronous active-high reset sets the process index to 0 and shared_active to 0, and clears every register in every bank to zero.
- R2: When pid_we is high at a rising clock edge, the process index takes the value of pid_in. Otherwise it holds its value. The current index is always visible on cur_pid.
- R3: shared_active is 1 exactly when the current process index is 16 or more, that is, when any of index bits 7 to 4 is set.
- R4: Index values 0 to 15 each address their own bank. A write made under one of these indices is never visible under any other index.
- R5: All index values from 16 to 255 address the same single shared bank. A write made under any one of them is visible under all the others.
- R6: A write lands at the rising edge where wr_en is high. It goes to the bank of the index in effect before that edge, even when pid_we loads a new index on the same edge. The new value shows on the read ports after that edge.
- R7: Both read ports are combinational and independent. Each returns the register named by its own 5-bit address in the current bank, and both may name the same register.
- R8: No register is hardwired. Register number 0 can be written and read back like any other register.
- R9: The 32 registers within one bank are distinct storage. Writing one register leaves the other 31 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pid_we | input | 1 | Load strobe for the process index |
| pid_in | input | 8 | New process index |
| cur_pid | output | 8 | Current process index |
| shared_active | output | 1 | High when the current index uses the shared bank |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Register number to write |
| wr_data | input | 32 | Write data |
| rd0_addr | input | 5 | Register number for read port 0 |
| rd0_data | output | 32 | Read data of port 0 |
| rd1_addr | input | 5 | Register number for read port 1 |
| rd1_data | output | 32 | Read data of port 1 |

## Verification
The reads are combinational, so a wrong bank select or a corrupted register shows on rd0_data or rd1_data in the same cycle that register is named. The bench names registers on every clock against a behavioural model. A wrong index load shows at once on cur_pid and shared_active. A write that lands in the wrong bank stays hidden until the bench reads that register under the affected index. For this reason the tests switch between dedicated and shared indices on purpose. They also load a new index on the same edge as a write.

// File: rtl/ctxrf_pkg.sv
package ctxrf_pkg;
  localparam int unsigned CTX_DED_BANKS = 16;
  localparam int unsigned CTX_PID_W     = 8;
  localparam int unsigned CTX_RN_W      = 5;
  localparam int unsigned CTX_DATA_W    = 32;
endpackage

// File: rtl/ctxrf_pid_reg.sv
module ctxrf_pid_reg #(
  parameter int unsigned PID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PID_W-1:0] din,
  output logic [PID_W-1:0] pid_q
);
  always_ff @(posedge clk) begin
    if (rst) pid_q <= '0;
    else if (load) pid_q <= din;
  end

  a_r1_pid_reset: assert property (@(posedge clk) rst |=> pid_q == '0);
  a_r2_pid_load:  assert property (@(posedge clk) disable iff (rst)
                                   load |=> pid_q == $past(din));
  a_r2_pid_hold:  assert property (@(posedge clk) disable iff (rst)
                                   !load |=> $stable(pid_q));
endmodule

// File: rtl/ctxrf_bank_sel.sv
module ctxrf_bank_sel #(
  parameter int unsigned PID_W     = 8,
  parameter int unsigned DED_BANKS = 16,
  localparam int unsigned SEL_W    = $clog2(DED_BANKS),
  localparam int unsigned BK_W     = $clog2(DED_BANKS + 1)
) (
  input  logic [PID_W-1:0] pid,
  output logic             use_shared,
  output logic [BK_W-1:0]  bank
);
  generate
    if (PID_W > SEL_W) begin : g_upper
      assign use_shared = |pid[PID_W-1:SEL_W];
    end else begin : g_none
      assign use_shared = 1'b0;
    end
  endgenerate

  always_comb begin
    if (use_shared) bank = BK_W'(DED_BANKS);
    else            bank = BK_W'(pid[SEL_W-1:0]);
  end
endmodule

// File: rtl/ctxrf_store.sv
module ctxrf_store #(
  parameter int unsigned DEPTH  = 544,
  parameter int unsigned AW     = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NRD    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr [NRD],
  output logic [DATA_W-1:0] rdata [NRD]
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    for (genvar r = 0; r < int'(NRD); r++) begin : g_rd
      assign rdata[r] = mem[raddr[r]];
    end
  endgenerate

  a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
                                     we |=> mem[$past(waddr)] == $past(wdata));
  a_r4_waddr_range: assert property (@(posedge clk) disable iff (rst)
                                     we |-> int'(waddr) < int'(DEPTH));
endmodule

// File: rtl/ctxrf_top.sv
module ctxrf_top
  import ctxrf_pkg::*;
#(
  parameter int unsigned DED_BANKS = CTX_DED_BANKS,
  parameter int unsigned PID_W     = CTX_PID_W,
  parameter int unsigned RN_W      = CTX_RN_W,
  parameter int unsigned DATA_W    = CTX_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pid_we,
  input  logic [PID_W-1:0]  pid_in,
  output logic [PID_W-1:0]  cur_pid,
  output logic              shared_active,
  input  logic              wr_en,
  input  logic [RN_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [RN_W-1:0]   rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [RN_W-1:0]   rd1_addr,
  output logic [DATA_W-1:0] rd1_data
);
  localparam int unsigned BK_W   = $clog2(DED_BANKS + 1);
  localparam int unsigned PA_W   = BK_W + RN_W;
  localparam int unsigned NREG   = 1 << RN_W;
  localparam int unsigned DEPTH  = (DED_BANKS + 1) * NREG;
  localparam int unsigned NRD    = 2;

  logic [BK_W-1:0]   bank;
  logic [RN_W-1:0]   rd_rn [NRD];
  logic [PA_W-1:0]   rd_pa [NRD];
  logic [DATA_W-1:0] rd_q  [NRD];
  logic [PA_W-1:0]   wr_pa;

  ctxrf_pid_reg #(.PID_W(PID_W)) u_pid (
    .clk(clk), .rst(rst), .load(pid_we), .din(pid_in), .pid_q(cur_pid)
  );

  ctxrf_bank_sel #(.PID_W(PID_W), .DED_BANKS(DED_BANKS)) u_sel (
    .pid(cur_pid), .use_shared(shared_active), .bank(bank)
  );

  assign rd_rn[0] = rd0_addr;
  assign rd_rn[1] = rd1_addr;

  generate
    for (genvar p = 0; p < int'(NRD); p++) begin : g_port
      assign rd_pa[p] = {bank, rd_rn[p]};
    end
  endgenerate

  assign wr_pa    = {bank, wr_addr};
  assign rd0_data = rd_q[0];
  assign rd1_data = rd_q[1];

  ctxrf_store #(.DEPTH(DEPTH), .AW(PA_W), .DATA_W(DATA_W), .NRD(NRD)) u_store (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_pa), .wdata(wr_data),
    .raddr(rd_pa), .rdata(rd_q)
  );

  a_r3_shared_flag: assert property (@(posedge clk) disable iff (rst)
                                     shared_active == (int'(cur_pid) >= int'(DED_BANKS)));
  a_r1_flag_reset:  assert property (@(posedge clk) rst |=> !shared_active);
endmodule

// File: tb/test_ctxrf_top.sv
module test_ctxrf_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        pid_we;
  logic [7:0]  pid_in;
  logic [7:0]  cur_pid;
  logic        shared_active;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic [4:0]  rd0_addr;
  logic [31:0] rd0_data;
  logic [4:0]  rd1_addr;
  logic [31:0] rd1_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] mdl [17][32];
  int m_pid = 0;

  always #10 clk = ~clk;

  ctxrf_top i_ctxrf_top (
    .clk(clk), .rst(rst), .pid_we(pid_we), .pid_in(pid_in), .cur_pid(cur_pid),
    .shared_active(shared_active), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data)
  );

  function automatic int bank_of(int p);
    return (p >= 16) ? 16 : p;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: drive after the falling edge, compare before the rising edge,
  // then advance the model at the rising edge.
  task automatic step(string req, bit we, int wa, logic [31:0] wd,
                      bit pwe, int pin, int ra0, int ra1);
    wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    pid_we = pwe; pid_in = 8'(pin);
    rd0_addr = 5'(ra0); rd1_addr = 5'(ra1);
    #2;
    check({req, " rd0"}, rd0_data, mdl[bank_of(m_pid)][ra0]);
    check({req, " rd1"}, rd1_data, mdl[bank_of(m_pid)][ra1]);
    check({req, " pid"}, 32'(cur_pid), 32'(m_pid));
    check({req, " R3 shared"}, 32'(shared_active), 32'(m_pid >= 16));
    @(posedge clk);
    if (we) mdl[bank_of(m_pid)][wa] = wd;
    if (pwe) m_pid = pin;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 17; b++)
      for (int r = 0; r < 32; r++) mdl[b][r] = '0;
    rst = 1'b1; pid_we = 1'b0; pid_in = 8'hA5; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd0_addr = '0; rd1_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, every register of bank 0 reads zero
    for (int r = 0; r < 32; r += 2) step("R1 reset", 0, 0, 0, 0, 0, r, r + 1);
    // R8: register 0 is writable
    step("R8 write r0", 1, 0, 32'hDEAD_0000, 0, 0, 0, 0);
    step("R8 read r0", 0, 0, 0, 1, 5, 0, 0);
    // R4: bank 5 does not see bank 0
    step("R4 other bank", 1, 0, 32'h5555_0005, 1, 0, 0, 0);
    step("R4 back to 0", 0, 0, 0, 1, 5, 0, 1);
    step("R4 bank5 kept", 0, 0, 0, 1, 16, 0, 0);
    // R5: shared bank across 16, 200, 255
    step("R5 write shared", 1, 7, 32'h1717_0007, 1, 200, 7, 0);
    step("R5 read via 200", 0, 0, 0, 1, 255, 7, 7);
    step("R5 read via 255", 0, 0, 0, 1, 15, 7, 0);
    step("R5 R4 bank15 clean", 0, 0, 0, 0, 0, 7, 0);
    // R6: write on same edge as index change goes to old bank
    step("R6 same edge", 1, 9, 32'hCAFE_0009, 1, 3, 9, 9);
    step("R6 new bank", 0, 0, 0, 1, 15, 9, 9);
    step("R6 old bank", 0, 0, 0, 1, 3, 9, 9);
    // R9 and R7: fill bank 3 with distinct values, read on both ports
    for (int r = 0; r < 32; r++)
      step("R9 fill", 1, r, 32'h3300_0000 + 32'(r * 17), 0, 0, r, 31 - r);
    for (int r = 0; r < 32; r++) step("R7 dual read", 0, 0, 0, 0, 0, r, 31 - r);
    // R9: overwrite one register, neighbours unchanged
    step("R9 single write", 1, 12, 32'hFFFF_FFFF, 0, 0, 11, 13);
    step("R9 neighbours", 0, 0, 0, 0, 0, 12, 13);
    // R2: hold index with pid_in changing but pid_we low
    step("R2 hold", 0, 0, 0, 0, 99, 0, 1);
    step("R2 hold check", 0, 0, 0, 0, 77, 0, 1);
    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int pin;
      pin = ($urandom_range(0, 3) == 0) ? int'($urandom_range(16, 255))
                                        : int'($urandom_range(0, 15));
      step("R4 R5 mixed", bit'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
           $urandom, ($urandom_range(0, 7) == 0), pin,
           int'($urandom_range(0, 31)), int'($urandom_range(0, 31)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule